// File: doc/BRIEF.md
# Sixteen-Pin General Purpose I/O Port

This block is one 16-pin general purpose I/O port seen by software through a small word-addressed register bus. Every pin has a 4-bit configuration field that chooses between input and output use and the flavour of each: analog, floating or pulled input, and push-pull or open-drain output driven either by the port's own output data register or by an alternate-function value from another block. Toward the pad models the port produces, per pin, the value to drive, the drive enable, and the pull-up and pull-down enables.

Software changes output bits in three ways: by a plain write of the output data register, by a combined set/clear write that handles both actions in one word without reading first, and by a clear-only write. Pin levels are resynchronised into the clock domain and read back from an input data register. A per-pin lock mask from outside freezes the configuration field of the pins it marks, while the data registers stay writable.

Top module: `gpioPort`

## Requirements
- R1: After reset every configuration field holds 4'h4 (floating input), so both configuration words read 32'h44444444; the output data register reads 0, and no pin drives or pulls.
- R2: The configuration field of pin p sits in the word at address 0 for pins 0 to 7 and at address 1 for pins 8 to 15, at bit offset 4*(p mod 8); bits [1:0] of a field are the mode (00 input, any other value output) and bits [3:2] the configuration code. Both words read back what was written.
- R3: With mode 00, code 10 enables a pull whose direction is the pin's output data bit (1 pulls up, 0 pulls down); codes 00, 01 and 11 enable no pull; an input pin never drives.
- R4: With a non-zero mode and code 00, the pin drives with the enable high and the value equal to its output data bit; no pull is enabled in any output mode.
- R5: With a non-zero mode and an odd code (01 or 11, open-drain), the enable is high only while the selected value is 0 and the driven value is always 0.
- R6: With a non-zero mode and code 10 or 11, the selected value comes from the pin's alternate-function input instead of the output data register.
- R7: A write to address 4 sets the output bits marked by ones in bits [15:0] and clears those marked in bits [31:16]; a pin marked in both halves ends set.
- R8: A write to address 5 clears the output bits marked by ones in bits [15:0]; bits [31:16] have no effect.
- R9: The input data register (address 2, bits [15:0]) shows the pin levels after two clock edges of resynchronisation.
- R10: A configuration write leaves unchanged the field of every pin whose lock mask bit is set, and updates the other fields of the written word.
- R11: Address 3 is the output data register and is written and read directly; addresses 4 and 5 and unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe for the addressed register |
| addr | input | 3 | Word address of the register |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data of the addressed register (combinational) |
| padIn | input | 16 | Pin levels from the pads |
| afIn | input | 16 | Alternate-function output values per pin |
| lockMask | input | 16 | Per-pin configuration lock |
| padOut | output | 16 | Value driven on each pin |
| padOe | output | 16 | Drive enable per pin |
| pullUp | output | 16 | Pull-up enable per pin |
| pullDown | output | 16 | Pull-down enable per pin |

## Verification
Two functions meet in one cycle when the set half and the clear half of a single set/clear write mark the same pin; the bench provokes this on pins that start both low and high and judges it by reading the output data register afterwards, where the set must have won. A second overlap is a configuration write landing on a word whose pins are partly locked: the bench writes a full word with two pins locked and checks through readback that only the unlocked fields moved. Pad outputs are compared against a bench-side model of the mode table after every change of configuration, output data or alternate-function input.

// File: rtl/gpioPortPkg.sv
package gpioPortPkg;

  localparam int PIN_COUNT  = 16;
  localparam int FIELD_W    = 4;
  localparam int WORD_W     = 32;
  localparam int ADDR_W     = 3;
  localparam int SYNC_DEPTH = 2;
  localparam logic [FIELD_W-1:0] FIELD_RESET = 4'h4;

  typedef enum logic [ADDR_W-1:0] {
    RS_CFG_LO = 3'd0,
    RS_CFG_HI = 3'd1,
    RS_IN     = 3'd2,
    RS_OUT    = 3'd3,
    RS_SETCLR = 3'd4,
    RS_CLR    = 3'd5,
    RS_NONE   = 3'd7
  } regSel_t;

  typedef struct packed {
    logic cfgLoWr;
    logic cfgHiWr;
    logic odrWr;
    logic setClrWr;
    logic clrWr;
  } gpioStrobe_t;

endpackage

// File: rtl/gpioCtrl.sv
module gpioCtrl
  import gpioPortPkg::*;
#(
  parameter int ADDR_BITS = ADDR_W
) (
  input  logic                 wrEn,
  input  logic [ADDR_BITS-1:0] addr,
  output gpioStrobe_t          strobe,
  output regSel_t              rdSel
);

  always_comb begin
    strobe = '0;
    rdSel  = RS_NONE;
    case (addr)
      3'd0: begin rdSel = RS_CFG_LO; strobe.cfgLoWr  = wrEn; end
      3'd1: begin rdSel = RS_CFG_HI; strobe.cfgHiWr  = wrEn; end
      3'd2: begin rdSel = RS_IN;                              end
      3'd3: begin rdSel = RS_OUT;    strobe.odrWr    = wrEn; end
      3'd4: begin rdSel = RS_SETCLR; strobe.setClrWr = wrEn; end
      3'd5: begin rdSel = RS_CLR;    strobe.clrWr    = wrEn; end
      default: rdSel = RS_NONE;
    endcase
  end

endmodule

// File: rtl/gpioDatapath.sv
module gpioDatapath
  import gpioPortPkg::*;
#(
  parameter int NUM_PINS = PIN_COUNT,
  parameter int FLD_W    = FIELD_W,
  parameter int BUS_W    = WORD_W,
  parameter int SYNC_N   = SYNC_DEPTH
) (
  input  logic                clk,
  input  logic                rstN,
  input  gpioStrobe_t         strobe,
  input  regSel_t             rdSel,
  input  logic [BUS_W-1:0]    wrData,
  input  logic [NUM_PINS-1:0] padIn,
  input  logic [NUM_PINS-1:0] afIn,
  input  logic [NUM_PINS-1:0] lockMask,
  output logic [BUS_W-1:0]    rdData,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOe,
  output logic [NUM_PINS-1:0] pullUp,
  output logic [NUM_PINS-1:0] pullDown,
  output logic [BUS_W-1:0]    cfgLoWord,
  output logic [BUS_W-1:0]    cfgHiWord,
  output logic [NUM_PINS-1:0] odrWord,
  output logic [NUM_PINS-1:0] idrWord
);

  localparam int PER_WORD = BUS_W / FLD_W;
  localparam int HALF_W   = BUS_W / 2;

  logic [NUM_PINS-1:0]       odrQ;
  logic [NUM_PINS-1:0]       syncQ [SYNC_N];
  logic [NUM_PINS*FLD_W-1:0] cfgFlat;

  // Output data: direct write, then set/clear (set wins), then clear-only
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      odrQ <= '0;
    end else if (strobe.odrWr) begin
      odrQ <= wrData[NUM_PINS-1:0];
    end else if (strobe.setClrWr) begin
      odrQ <= (odrQ & ~wrData[HALF_W +: NUM_PINS]) | wrData[NUM_PINS-1:0];
    end else if (strobe.clrWr) begin
      odrQ <= odrQ & ~wrData[NUM_PINS-1:0];
    end
  end

  // Input resynchroniser chain
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_N; s++) syncQ[s] <= '0;
    end else begin
      syncQ[0] <= padIn;
      for (int s = 1; s < SYNC_N; s++) syncQ[s] <= syncQ[s-1];
    end
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam int WORD_SEL = p / PER_WORD;
    localparam int OFS      = (p % PER_WORD) * FLD_W;

    logic [FLD_W-1:0] fieldQ;
    logic             fieldWr;
    logic             isOut;
    logic             isOpen;
    logic             selVal;

    if (WORD_SEL == 0) begin : g_lo
      assign fieldWr = strobe.cfgLoWr & ~lockMask[p];
    end else begin : g_hi
      assign fieldWr = strobe.cfgHiWr & ~lockMask[p];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)        fieldQ <= FIELD_RESET;
      else if (fieldWr) fieldQ <= wrData[OFS +: FLD_W];
    end

    assign cfgFlat[p*FLD_W +: FLD_W] = fieldQ;

    assign isOut  = |fieldQ[1:0];
    assign isOpen = fieldQ[2];
    assign selVal = fieldQ[3] ? afIn[p] : odrQ[p];

    assign padOe[p]    = isOut & (~isOpen | ~selVal);
    assign padOut[p]   = isOut & ~isOpen & selVal;
    assign pullUp[p]   = ~isOut & (fieldQ[3:2] == 2'b10) &  odrQ[p];
    assign pullDown[p] = ~isOut & (fieldQ[3:2] == 2'b10) & ~odrQ[p];
  end

  assign cfgLoWord = cfgFlat[BUS_W-1:0];
  assign cfgHiWord = cfgFlat[2*BUS_W-1:BUS_W];
  assign odrWord   = odrQ;
  assign idrWord   = syncQ[SYNC_N-1];

  always_comb begin
    case (rdSel)
      RS_CFG_LO: rdData = cfgLoWord;
      RS_CFG_HI: rdData = cfgHiWord;
      RS_IN:     rdData = BUS_W'(syncQ[SYNC_N-1]);
      RS_OUT:    rdData = BUS_W'(odrQ);
      default:   rdData = '0;
    endcase
  end

endmodule

// File: rtl/gpioPort.sv
module gpioPort
  import gpioPortPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wrData,
  output logic [WORD_W-1:0] rdData,
  input  logic [PIN_COUNT-1:0] padIn,
  input  logic [PIN_COUNT-1:0] afIn,
  input  logic [PIN_COUNT-1:0] lockMask,
  output logic [PIN_COUNT-1:0] padOut,
  output logic [PIN_COUNT-1:0] padOe,
  output logic [PIN_COUNT-1:0] pullUp,
  output logic [PIN_COUNT-1:0] pullDown
);

  gpioStrobe_t          strobe;
  regSel_t              rdSel;
  logic [WORD_W-1:0]    cfgLoWord;
  logic [WORD_W-1:0]    cfgHiWord;
  logic [PIN_COUNT-1:0] odrWord;
  logic [PIN_COUNT-1:0] idrWord;

  gpioCtrl #(.ADDR_BITS(ADDR_W)) u_ctrl (
    .wrEn   (wrEn),
    .addr   (addr),
    .strobe (strobe),
    .rdSel  (rdSel)
  );

  gpioDatapath #(
    .NUM_PINS (PIN_COUNT),
    .FLD_W    (FIELD_W),
    .BUS_W    (WORD_W),
    .SYNC_N   (SYNC_DEPTH)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .rdSel     (rdSel),
    .wrData    (wrData),
    .padIn     (padIn),
    .afIn      (afIn),
    .lockMask  (lockMask),
    .rdData    (rdData),
    .padOut    (padOut),
    .padOe     (padOe),
    .pullUp    (pullUp),
    .pullDown  (pullDown),
    .cfgLoWord (cfgLoWord),
    .cfgHiWord (cfgHiWord),
    .odrWord   (odrWord),
    .idrWord   (idrWord)
  );

endmodule

// File: rtl/gpioPortChk.sv
module gpioPortChk
  import gpioPortPkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 wrEn,
  input logic [ADDR_W-1:0]    addr,
  input logic [WORD_W-1:0]    wrData,
  input logic [PIN_COUNT-1:0] padIn,
  input logic [PIN_COUNT-1:0] lockMask,
  input logic [PIN_COUNT-1:0] padOut,
  input logic [WORD_W-1:0]    cfgLoWord,
  input logic [WORD_W-1:0]    cfgHiWord,
  input logic [PIN_COUNT-1:0] odrWord,
  input logic [PIN_COUNT-1:0] idrWord
);

  localparam int PER_WORD = WORD_W / FIELD_W;

  logic [WORD_W-1:0]    lockLoX;
  logic [WORD_W-1:0]    lockHiX;
  logic [PIN_COUNT-1:0] odMask;
  logic [1:0]           sinceRst;

  always_comb begin
    for (int i = 0; i < PER_WORD; i++) begin
      lockLoX[i*FIELD_W +: FIELD_W] = {FIELD_W{lockMask[i]}};
      lockHiX[i*FIELD_W +: FIELD_W] = {FIELD_W{lockMask[i+PER_WORD]}};
    end
    for (int i = 0; i < PIN_COUNT; i++) begin
      if (i < PER_WORD)
        odMask[i] = (|cfgLoWord[i*FIELD_W +: 2]) & cfgLoWord[i*FIELD_W+2];
      else
        odMask[i] = (|cfgHiWord[(i-PER_WORD)*FIELD_W +: 2]) & cfgHiWord[(i-PER_WORD)*FIELD_W+2];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                sinceRst <= '0;
    else if (sinceRst != 2'd2) sinceRst <= sinceRst + 2'd1;
  end

  a_r1_reset_fields: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (cfgLoWord == 32'h44444444 && cfgHiWord == 32'h44444444 && odrWord == '0));

  a_r5_open_drain_low: assert property (@(posedge clk) disable iff (!rstN)
    (padOut & odMask) == '0);

  a_r7_set_half: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 3'd4) |=> ((odrWord & $past(wrData[15:0])) == $past(wrData[15:0])));

  a_r7_clear_half: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 3'd4) |=> ((odrWord & $past(wrData[31:16] & ~wrData[15:0])) == '0));

  a_r8_clear_only: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 3'd5) |=> ((odrWord & $past(wrData[15:0])) == '0));

  a_r9_sync_latency: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd2) |-> (idrWord == $past(padIn, 2)));

  a_r10_lock_low: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 3'd0) |=> (((cfgLoWord ^ $past(cfgLoWord)) & $past(lockLoX)) == '0));

  a_r10_lock_high: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 3'd1) |=> (((cfgHiWord ^ $past(cfgHiWord)) & $past(lockHiX)) == '0));

endmodule

bind gpioPort gpioPortChk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .wrEn      (wrEn),
  .addr      (addr),
  .wrData    (wrData),
  .padIn     (padIn),
  .lockMask  (lockMask),
  .padOut    (padOut),
  .cfgLoWord (cfgLoWord),
  .cfgHiWord (cfgHiWord),
  .odrWord   (odrWord),
  .idrWord   (idrWord)
);

// File: tb/gpioPort_tb.sv
module gpioPort_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [15:0] padIn = '0;
  logic [15:0] afIn = '0;
  logic [15:0] lockMask = '0;
  logic [15:0] padOut, padOe, pullUp, pullDown;

  always #4 clk = ~clk;

  gpioPort u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .padIn(padIn), .afIn(afIn), .lockMask(lockMask),
    .padOut(padOut), .padOe(padOe), .pullUp(pullUp), .pullDown(pullDown)
  );

  typedef struct {
    int          kind;   // 0 rdData, 1 padOut, 2 padOe, 3 pullUp, 4 pullDown
    logic [31:0] expVal;
    string       tag;
  } item_t;

  item_t       sbQ[$];
  int          nVec = 0;
  int          nBad = 0;
  bit          done = 0;
  logic [31:0] mLo = 32'h44444444;
  logic [31:0] mHi = 32'h44444444;
  logic [15:0] mOdr = '0;

  // Monitor: compare everything queued for this cycle
  initial begin
    forever begin
      @(negedge clk);
      while (sbQ.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = sbQ.pop_front();
        case (it.kind)
          0: act = rdData;
          1: act = {16'h0, padOut};
          2: act = {16'h0, padOe};
          3: act = {16'h0, pullUp};
          default: act = {16'h0, pullDown};
        endcase
        nVec++;
        if (act !== it.expVal) begin
          nBad++;
          $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.expVal);
        end
      end
    end
  end

  task automatic settle();
    @(posedge clk); #1;
  endtask

  task automatic busWrite(input logic [2:0] a, input logic [31:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic expectRead(input logic [2:0] a, input logic [31:0] v, input string tag);
    addr = a;
    sbQ.push_back('{0, v, tag});
    settle();
  endtask

  // Bench model of the pin mode table from the requirements
  task automatic checkPads(input string tag);
    logic [15:0] eOut, eOe, eUp, eDn;
    eOut = '0; eOe = '0; eUp = '0; eDn = '0;
    for (int i = 0; i < 16; i++) begin
      logic [3:0] f;
      logic v;
      f = (i < 8) ? mLo[i*4 +: 4] : mHi[(i-8)*4 +: 4];
      if (f[1:0] == 2'b00) begin
        if (f[3:2] == 2'b10) begin
          eUp[i] = mOdr[i];
          eDn[i] = ~mOdr[i];
        end
      end else begin
        v = f[3] ? afIn[i] : mOdr[i];
        if (f[2]) eOe[i] = ~v;
        else begin eOe[i] = 1'b1; eOut[i] = v; end
      end
    end
    sbQ.push_back('{1, {16'h0, eOut}, tag});
    sbQ.push_back('{2, {16'h0, eOe},  tag});
    sbQ.push_back('{3, {16'h0, eUp},  tag});
    sbQ.push_back('{4, {16'h0, eDn},  tag});
    settle();
  endtask

  // Watchdog
  initial begin
    #(8 * 100000);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    settle();

    // R1 reset state
    expectRead(3'd0, 32'h44444444, "R1 cfg low");
    expectRead(3'd1, 32'h44444444, "R1 cfg high");
    expectRead(3'd3, 32'h0, "R1 odr");
    checkPads("R1 pads idle");

    // R2 field placement and readback
    busWrite(3'd0, 32'h8408D951); mLo = 32'h8408D951;
    busWrite(3'd1, 32'h12345678); mHi = 32'h12345678;
    expectRead(3'd0, 32'h8408D951, "R2 cfg low readback");
    expectRead(3'd1, 32'h12345678, "R2 cfg high readback");

    // R3..R6 pad behaviour across data patterns
    afIn = 16'h0000;
    checkPads("R3 R4 R5 R6 odr0 af0");
    busWrite(3'd3, 32'h0000FFFF); mOdr = 16'hFFFF;
    checkPads("R3 R4 R5 odr1 af0");
    afIn = 16'hFFFF;
    checkPads("R5 R6 odr1 af1");
    busWrite(3'd3, 32'h00000000); mOdr = 16'h0000;
    checkPads("R6 odr0 af1");
    afIn = 16'h5A5A;
    busWrite(3'd3, 32'h000033CC); mOdr = 16'h33CC;
    checkPads("R3 R4 R5 R6 mixed");

    // R11 direct write and write-only readback
    busWrite(3'd3, 32'hABCD00FF); mOdr = 16'h00FF;
    expectRead(3'd3, 32'h000000FF, "R11 odr direct");
    expectRead(3'd4, 32'h0, "R11 setclr reads 0");
    expectRead(3'd5, 32'h0, "R11 clr reads 0");
    expectRead(3'd7, 32'h0, "R11 unused reads 0");

    // R7 set/clear halves
    busWrite(3'd4, 32'h000F0130); mOdr = 16'h01F0;
    expectRead(3'd3, 32'h000001F0, "R7 set and clear");
    busWrite(3'd4, 32'h01000100);
    expectRead(3'd3, 32'h000001F0, "R7 both halves on set pin");
    busWrite(3'd4, 32'h02000200); mOdr = 16'h03F0;
    expectRead(3'd3, 32'h000003F0, "R7 both halves on clear pin");
    checkPads("R7 pads follow odr");

    // R8 clear only, high half ignored
    busWrite(3'd5, 32'hFFFF0030); mOdr = 16'h03C0;
    expectRead(3'd3, 32'h000003C0, "R8 clear only");

    // R9 input sync latency
    padIn = 16'hA5C3;
    settle();
    expectRead(3'd2, 32'h0, "R9 before two edges");
    expectRead(3'd2, 32'h0000A5C3, "R9 after two edges");
    padIn = 16'h0F0F;
    settle(); settle();
    expectRead(3'd2, 32'h00000F0F, "R9 second pattern");

    // R10 lock mask
    lockMask = 16'h0101;
    busWrite(3'd0, 32'h44444444);
    busWrite(3'd1, 32'h44444444);
    mLo = 32'h44444441; mHi = 32'h44444448;
    expectRead(3'd0, 32'h44444441, "R10 locked pin0 kept");
    expectRead(3'd1, 32'h44444448, "R10 locked pin8 kept");
    busWrite(3'd3, 32'h00001234); mOdr = 16'h1234;
    expectRead(3'd3, 32'h00001234, "R10 odr not locked");
    checkPads("R10 pads after lock");
    lockMask = 16'h0000;
    busWrite(3'd0, 32'h44444444); mLo = 32'h44444444;
    expectRead(3'd0, 32'h44444444, "R10 unlocked write");

    done = 1;
    settle();
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

endmodule